// File: doc/BRIEF.md
# Single-Place Event Buffer Wrapper

This block sits between the outside world and a reactive controller whose transition logic lives elsewhere. Every input port carries short event pulses with a data value. A one-bit presence latch remembers that at least one pulse arrived since the controller last reacted, and a value register keeps the most recent value. When the controller reacts (the `go` strobe), the block presents the latched presence ORed with any pulse arriving in that same cycle, then clears the latch. A pulse in the reaction cycle is forwarded directly and is not stored.

Every output port has a pending-emit bit and a two-stage value store. At a reaction the controller's emit request is loaded into the pending bit, and its value is captured into the internal stage. The pending event reaches the port either between reactions, when the per-port emit enable is high, or at the latest at the next reaction, which forces out the old pending event before loading the new request. While an event is on the port, the internal value is shown; at that edge it is copied into the external stage, which is what the port shows between events.

Events are single-cycle pulses with no back-pressure: there is no ready signal on either side. An input pulse is never refused. An output pulse is not acknowledged, and the consumer must take it in the cycle it is shown. `go` and the emit enables are plain control pins.

Top module: `evbuf_wrap`

## Requirements
- R1: After reset every input presence latch is 0, so `ctl_pres` is 0 at the first reaction when no pulses arrive. Every output pending bit is 0, except on ports whose bit in `OUT_INIT` is 1, where it is 1. Both value stages of every output reset to `INIT_VAL`.
- R2: While `go` is 1, `ctl_pres[i]` equals the latched presence OR `in_evt[i]`. The latch is 0 after that edge. While `go` is 0, `ctl_pres` is all zero.
- R3: An input pulse in the same cycle as `go` is seen in `ctl_pres` during that cycle but is not latched, so the next reaction without a new pulse shows 0.
- R4: Several pulses between two reactions merge into one presence bit. `ctl_val[i]` shows `in_val[i]` in a cycle with a pulse, and otherwise the value of the most recent pulse.
- R5: In a `go` cycle, `out_evt[j]` equals the pending bit before that edge, whatever `emit_en` is. The pending bit then takes `ctl_emit[j]`, so a pending event is never carried past the next reaction.
- R6: With `go` low, a pending event is emitted in a cycle where `emit_en[j]` is 1 and then clears. While `emit_en[j]` is 0 it stays pending and `out_evt[j]` is 0.
- R7: The internal value stage captures `ctl_oval[j]` at a `go` edge with `ctl_emit[j]` high. While `out_evt[j]` is 1, `out_val[j]` shows the internal stage. In other cycles it shows the external stage, which takes the internal value at each emission edge.
- R8: A port with an initial event emits it, carrying `INIT_VAL`, at its first emit-enabled cycle or first reaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_evt | input | N_IN | Input event pulses, one per port |
| in_val | input | N_IN*VAL_W | Input event values, port i at bits [i*VAL_W +: VAL_W] |
| go | input | 1 | Controller reaction strobe |
| ctl_pres | output | N_IN | Presence handed to the controller during `go` |
| ctl_val | output | N_IN*VAL_W | Input values handed to the controller |
| ctl_emit | input | N_OUT | Controller emit request, sampled with `go` |
| ctl_oval | input | N_OUT*VAL_W | Controller output values, sampled with `go` |
| emit_en | input | N_OUT | Allow emission of a pending event between reactions |
| out_evt | output | N_OUT | Emitted output event pulses |
| out_val | output | N_OUT*VAL_W | Output values, port j at bits [j*VAL_W +: VAL_W] |

## Verification
Two functions can fall in the same cycle on each side. On inputs, a pulse can arrive together with `go`. The bench drives both at once and checks that the pulse shows in `ctl_pres` in that cycle and is absent at the next empty reaction. On outputs, a forced emission and a new capture can share one `go` edge. The bench issues two emit requests with different values at back-to-back reactions and checks that the first reaction's value is shown at the second reaction, and the second value at the third.

// File: rtl/evb_pkg.sv
package evb_pkg;
  parameter int unsigned EVB_VAL_W_DEF = 8;
  parameter int unsigned EVB_PORTS_DEF = 2;
endpackage

// File: rtl/evb_in_slot.sv
module evb_in_slot #(
  parameter int unsigned VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             evt,
  input  logic [VAL_W-1:0] val,
  output logic             pres,
  output logic [VAL_W-1:0] pval
);
  logic             lat_q;
  logic [VAL_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (go)       lat_q <= 1'b0;
      else if (evt) lat_q <= 1'b1;
      if (evt)      hold_q <= val;
    end
  end

  assign pres = go & (lat_q | evt);
  assign pval = evt ? val : hold_q;

  a_r4_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && evt) |=> lat_q);
  a_r3_no_latch_on_go: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !lat_q);
  a_r4_latest_value: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (hold_q == $past(val)));
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> !pres);
endmodule

// File: rtl/evb_out_slot.sv
module evb_out_slot #(
  parameter int unsigned VAL_W     = 8,
  parameter bit          INIT_PEND = 1'b0,
  parameter logic [VAL_W-1:0] INIT_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             en,
  input  logic             req,
  input  logic [VAL_W-1:0] rval,
  output logic             evt,
  output logic [VAL_W-1:0] oval
);
  logic             pend_q;
  logic [VAL_W-1:0] int_q;
  logic [VAL_W-1:0] ext_q;
  logic             fire;

  assign fire = pend_q & (go | en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= INIT_PEND;
      int_q  <= INIT_VAL;
      ext_q  <= INIT_VAL;
    end else begin
      if (go)      pend_q <= req;
      else if (en) pend_q <= 1'b0;
      if (go && req) int_q <= rval;
      if (fire)      ext_q <= int_q;
    end
  end

  assign evt  = fire;
  assign oval = fire ? int_q : ext_q;

  a_r5_load_request: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (pend_q == $past(req)));
  a_r5_deadline: assert property (@(posedge clk) disable iff (!rst_n)
    (go && pend_q) |-> evt);
  a_r6_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !en) |=> (pend_q == $past(pend_q)));
  a_r7_ext_follows: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (ext_q == $past(oval)));
endmodule

// File: rtl/evbuf_wrap.sv
module evbuf_wrap
  import evb_pkg::*;
#(
  parameter int unsigned N_IN  = EVB_PORTS_DEF,
  parameter int unsigned N_OUT = EVB_PORTS_DEF,
  parameter int unsigned VAL_W = EVB_VAL_W_DEF,
  parameter logic [N_OUT-1:0] OUT_INIT = 2'b10,
  parameter logic [VAL_W-1:0] INIT_VAL = 8'hA5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        in_evt,
  input  logic [N_IN*VAL_W-1:0]  in_val,
  input  logic                   go,
  output logic [N_IN-1:0]        ctl_pres,
  output logic [N_IN*VAL_W-1:0]  ctl_val,
  input  logic [N_OUT-1:0]       ctl_emit,
  input  logic [N_OUT*VAL_W-1:0] ctl_oval,
  input  logic [N_OUT-1:0]       emit_en,
  output logic [N_OUT-1:0]       out_evt,
  output logic [N_OUT*VAL_W-1:0] out_val
);
  localparam int unsigned IN_BITS  = N_IN * VAL_W;
  localparam int unsigned OUT_BITS = N_OUT * VAL_W;

  logic [IN_BITS-1:0]  in_val_w;
  logic [OUT_BITS-1:0] oval_w;

  assign in_val_w = in_val;
  assign oval_w   = ctl_oval;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    evb_in_slot #(.VAL_W(VAL_W)) u_in (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (go),
      .evt  (in_evt[i]),
      .val  (in_val_w[i*VAL_W +: VAL_W]),
      .pres (ctl_pres[i]),
      .pval (ctl_val[i*VAL_W +: VAL_W])
    );
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    evb_out_slot #(
      .VAL_W    (VAL_W),
      .INIT_PEND(OUT_INIT[j]),
      .INIT_VAL (INIT_VAL)
    ) u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (go),
      .en   (emit_en[j]),
      .req  (ctl_emit[j]),
      .rval (oval_w[j*VAL_W +: VAL_W]),
      .evt  (out_evt[j]),
      .oval (out_val[j*VAL_W +: VAL_W])
    );
  end

  a_r1_reset_no_pres: assert property (@(posedge clk)
    !rst_n |=> (ctl_pres == '0 || go));
endmodule

// File: tb/evbuf_wrap_tb.sv
module evbuf_wrap_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  in_evt = '0;
  logic [15:0] in_val = '0;
  logic        go = 1'b0;
  logic [1:0]  ctl_pres;
  logic [15:0] ctl_val;
  logic [1:0]  ctl_emit = '0;
  logic [15:0] ctl_oval = '0;
  logic [1:0]  emit_en = '0;
  logic [1:0]  out_evt;
  logic [15:0] out_val;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evbuf_wrap u_dut (
    .clk(clk), .rst_n(rst_n), .in_evt(in_evt), .in_val(in_val), .go(go),
    .ctl_pres(ctl_pres), .ctl_val(ctl_val), .ctl_emit(ctl_emit),
    .ctl_oval(ctl_oval), .emit_en(emit_en), .out_evt(out_evt), .out_val(out_val)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    in_evt = '0; go = 1'b0; ctl_emit = '0; emit_en = '0;
  endtask

  // inputs change at negedge, combinational outputs checked 1 time unit later
  task automatic step();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 no presence after reset", ctl_pres, 0);
    chk("R1 no emission without enable", out_evt, 0);
    emit_en = 2'b11; #1;
    chk("R8 initial event on port1 only", out_evt, 2'b10);
    chk("R8 initial value", out_val[15:8], 8'hA5);
    chk("R1 port0 external value", out_val[7:0], 8'hA5);
    step();
    emit_en = 2'b11; #1;
    chk("R6 initial event cleared", out_evt, 0);
    step();
  endtask

  task automatic t_in_merge();
    in_evt = 2'b01; in_val[7:0] = 8'h11; #1;
    chk("R2 no presence without go", ctl_pres, 0);
    chk("R4 live value", ctl_val[7:0], 8'h11);
    step();
    in_evt = 2'b01; in_val[7:0] = 8'h22;
    step();
    in_val[7:0] = 8'h99; go = 1'b1; #1;
    chk("R4 merged presence", ctl_pres, 2'b01);
    chk("R4 most recent value", ctl_val[7:0], 8'h22);
    step();
    go = 1'b1; #1;
    chk("R2 latch cleared by reaction", ctl_pres, 0);
    step();
  endtask

  task automatic t_coincide();
    go = 1'b1; in_evt = 2'b10; in_val[15:8] = 8'h33; #1;
    chk("R3 forwarded presence", ctl_pres, 2'b10);
    chk("R3 forwarded value", ctl_val[15:8], 8'h33);
    step();
    go = 1'b1; #1;
    chk("R3 coinciding pulse not latched", ctl_pres, 0);
    step();
  endtask

  task automatic t_out_enable();
    go = 1'b1; ctl_emit = 2'b01; ctl_oval[7:0] = 8'h44; #1;
    chk("R5 nothing pending at reaction", out_evt[0], 0);
    step();
    step();
    chk("R6 held while enable low", out_evt[0], 0);
    chk("R7 external value shown", out_val[7:0], 8'hA5);
    emit_en = 2'b01; #1;
    chk("R6 emitted on enable", out_evt[0], 1);
    chk("R7 internal value shown", out_val[7:0], 8'h44);
    step();
    chk("R7 external updated", out_val[7:0], 8'h44);
    emit_en = 2'b01; #1;
    chk("R6 cleared after emission", out_evt[0], 0);
    step();
  endtask

  task automatic t_out_forced();
    go = 1'b1; ctl_emit = 2'b01; ctl_oval[7:0] = 8'h55;
    step();
    go = 1'b1; ctl_emit = 2'b01; ctl_oval[7:0] = 8'h66; #1;
    chk("R5 forced emission at reaction", out_evt[0], 1);
    chk("R7 old value at forced emission", out_val[7:0], 8'h55);
    step();
    go = 1'b1; #1;
    chk("R5 second forced emission", out_evt[0], 1);
    chk("R7 new value captured", out_val[7:0], 8'h66);
    step();
    go = 1'b1; emit_en = 2'b01; #1;
    chk("R5 pending cleared by empty request", out_evt[0], 0);
    chk("R7 external keeps last value", out_val[7:0], 8'h66);
    step();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_in_merge();
    t_coincide();
    t_out_enable();
    t_out_forced();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule